// File: doc/BRIEF.md
# Bank-Wrapping Burst Address Counter

This block produces the working address for two memory ports. Each port has its own counter. On every rising clock edge the counter does one of four things. It can take an externally supplied address, step forward by one, keep its value, or return to the most recent externally supplied address. That last address is kept in a separate restore register, which the port refreshes every time it takes an external address.

The address is 18 bits wide. The upper 6 bits select a bank and the lower 12 bits give the position inside that bank. Stepping treats the two fields as a single number. When the offset is at its top value, the next step moves to offset zero of the following bank. Stepping from the very last location returns to bank 0, offset 0. The counters ignore every chip-select and byte-select condition, so they move only on their own three active-low controls.

A comparator can be built in at elaboration time. It raises a flag whenever both ports have the same bank selected, because an access by both ports to one bank is invalid. A synchronous reset clears both counters and both restore registers.

Top module: `burst_bank_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both port addresses and both restore registers become 0. A restore issued right after reset therefore yields address 0.
- R2: With `*_repeat_n` high and `*_load_n` low at a rising edge, the port address after that edge equals `*_addr_in`. The restore register captures the same value.
- R3: With `*_repeat_n` and `*_load_n` high and `*_count_n` low, the port address after the edge is the previous address plus one.
- R4: With all three controls high, the port address is unchanged across the edge.
- R5: With `*_repeat_n` low, the port address after the edge equals the restore register, whatever the values of `*_load_n`, `*_count_n` and `*_addr_in`.
- R6: When `*_load_n` and `*_count_n` are both low, and `*_repeat_n` is high, the port loads `*_addr_in` and does not count.
- R7: Counting from offset 0xFFF (bits 11:0) in bank n (bits 17:12) gives offset 0 in bank n+1. For example, 0x00FFF steps to 0x01000.
- R8: Counting from 0x3FFFF gives 0x00000.
- R9: Only a load (R2) changes the restore register. Counting, holding and restoring leave it as it was, and a load strobe that arrives while restore is active is not captured.
- R10: `bank_clash` is high exactly when bits 17:12 of `a_addr` and `b_addr` are equal.
- R11: The two ports are independent: the controls of one port never change the other port's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_addr_in | input | 18 | External address for port A |
| a_load_n | input | 1 | Port A load strobe, active low |
| a_count_n | input | 1 | Port A count enable, active low |
| a_repeat_n | input | 1 | Port A restore to last load, active low |
| a_addr | output | 18 | Port A address in use |
| b_addr_in | input | 18 | External address for port B |
| b_load_n | input | 1 | Port B load strobe, active low |
| b_count_n | input | 1 | Port B count enable, active low |
| b_repeat_n | input | 1 | Port B restore to last load, active low |
| b_addr | output | 18 | Port B address in use |
| bank_clash | output | 1 | Both ports select the same bank |

## Verification
The restore register cannot be read directly. The only way to see its value is to issue a restore and watch the address that follows. To show that counting, holding and a load blocked by restore left the register alone, the stimulus runs a sequence of restores. The sequence begins with a restore carrying a conflicting load strobe and a different external address, and a plain restore follows it. Both restores must return the earlier loaded value. The bank carry and the top-end wrap are reached by loading addresses two steps below each boundary and counting across it. The clash flag is reached by stepping one port across a bank boundary, onto and then off the other port's bank.

// File: rtl/bbac_pkg.sv
package bbac_pkg;
   localparam int NUM_PORTS = 2;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_COUNT  = 2'd1,
      OP_LOAD   = 2'd2,
      OP_REPEAT = 2'd3
   } addr_op_e;
endpackage

// File: rtl/bbac_op_decode.sv
module bbac_op_decode
   import bbac_pkg::*;
(
   input  logic     load_n,
   input  logic     count_n,
   input  logic     repeat_n,
   output addr_op_e op
);
   // restore beats load, load beats count
   always_comb begin
      if (!repeat_n)     op = OP_REPEAT;
      else if (!load_n)  op = OP_LOAD;
      else if (!count_n) op = OP_COUNT;
      else               op = OP_HOLD;
   end
endmodule

// File: rtl/bbac_incr.sv
module bbac_incr #(
   parameter int BANK_W    = 6,
   parameter int OFFS_W    = 12,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic [BANK_W+OFFS_W-1:0] cur,
   output logic [BANK_W+OFFS_W-1:0] nxt
);
   localparam int ADDR_W = BANK_W + OFFS_W;

   generate
      if (SPLIT_INC) begin : g_split
         // offset stepper hands a carry to a separate bank stepper
         logic [OFFS_W-1:0] offs_nx;
         logic [BANK_W-1:0] bank_nx;
         logic              offs_cy;
         always_comb begin
            {offs_cy, offs_nx} = {1'b0, cur[OFFS_W-1:0]} + {{OFFS_W{1'b0}}, 1'b1};
            bank_nx            = cur[ADDR_W-1:OFFS_W] + {{(BANK_W-1){1'b0}}, offs_cy};
            nxt                = {bank_nx, offs_nx};
         end
      end else begin : g_flat
         always_comb nxt = cur + {{(ADDR_W-1){1'b0}}, 1'b1};
      end
   endgenerate
endmodule

// File: rtl/bbac_port_counter.sv
module bbac_port_counter
   import bbac_pkg::*;
#(
   parameter int BANK_W    = 6,
   parameter int OFFS_W    = 12,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [BANK_W+OFFS_W-1:0] ext_addr,
   input  logic                     load_n,
   input  logic                     count_n,
   input  logic                     repeat_n,
   output logic [BANK_W+OFFS_W-1:0] cur_addr,
   output logic [BANK_W+OFFS_W-1:0] rst_addr
);
   localparam int ADDR_W = BANK_W + OFFS_W;

   addr_op_e          op;
   logic [ADDR_W-1:0] step_addr;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] keep_q;

   bbac_op_decode u_dec (
      .load_n   (load_n),
      .count_n  (count_n),
      .repeat_n (repeat_n),
      .op       (op)
   );

   bbac_incr #(
      .BANK_W    (BANK_W),
      .OFFS_W    (OFFS_W),
      .SPLIT_INC (SPLIT_INC)
   ) u_inc (
      .cur (cur_q),
      .nxt (step_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q  <= '0;
         keep_q <= '0;
      end else begin
         unique case (op)
            OP_LOAD: begin
               cur_q  <= ext_addr;
               keep_q <= ext_addr;
            end
            OP_COUNT:  cur_q <= step_addr;
            OP_REPEAT: cur_q <= keep_q;
            default:   cur_q <= cur_q;
         endcase
      end
   end

   assign cur_addr = cur_q;
   assign rst_addr = keep_q;
endmodule

// File: rtl/bbac_bank_match.sv
module bbac_bank_match #(
   parameter int BANK_W = 6,
   parameter bit ENABLE = 1'b1
) (
   input  logic [BANK_W-1:0] bank_a,
   input  logic [BANK_W-1:0] bank_b,
   output logic              clash
);
   generate
      if (ENABLE) begin : g_cmp
         assign clash = (bank_a == bank_b);
      end else begin : g_off
         assign clash = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/burst_bank_addr_gen.sv
module burst_bank_addr_gen
   import bbac_pkg::*;
#(
   parameter int BANK_W    = 6,
   parameter int OFFS_W    = 12,
   parameter bit SPLIT_INC = 1'b1,
   parameter bit CLASH_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [BANK_W+OFFS_W-1:0] a_addr_in,
   input  logic                     a_load_n,
   input  logic                     a_count_n,
   input  logic                     a_repeat_n,
   output logic [BANK_W+OFFS_W-1:0] a_addr,
   input  logic [BANK_W+OFFS_W-1:0] b_addr_in,
   input  logic                     b_load_n,
   input  logic                     b_count_n,
   input  logic                     b_repeat_n,
   output logic [BANK_W+OFFS_W-1:0] b_addr,
   output logic                     bank_clash
);
   localparam int ADDR_W = BANK_W + OFFS_W;
   localparam int NP     = NUM_PORTS;

   generate
      if (BANK_W < 1 || OFFS_W < 1) begin : g_bad_width
         $error("bank and offset fields need at least one bit each");
      end
      if (NP != 2) begin : g_bad_ports
         $error("bank compare expects exactly two ports");
      end
   endgenerate

   logic [NP-1:0][ADDR_W-1:0] ext_v;
   logic [NP-1:0][ADDR_W-1:0] cur_v;
   logic [NP-1:0][ADDR_W-1:0] keep_v;
   logic [NP-1:0]             ld_n_v;
   logic [NP-1:0]             cnt_n_v;
   logic [NP-1:0]             rpt_n_v;

   assign ext_v   = {b_addr_in, a_addr_in};
   assign ld_n_v  = {b_load_n, a_load_n};
   assign cnt_n_v = {b_count_n, a_count_n};
   assign rpt_n_v = {b_repeat_n, a_repeat_n};

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         bbac_port_counter #(
            .BANK_W    (BANK_W),
            .OFFS_W    (OFFS_W),
            .SPLIT_INC (SPLIT_INC)
         ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .ext_addr (ext_v[p]),
            .load_n   (ld_n_v[p]),
            .count_n  (cnt_n_v[p]),
            .repeat_n (rpt_n_v[p]),
            .cur_addr (cur_v[p]),
            .rst_addr (keep_v[p])
         );
      end
   endgenerate

   bbac_bank_match #(
      .BANK_W (BANK_W),
      .ENABLE (CLASH_EN)
   ) u_match (
      .bank_a (cur_v[0][ADDR_W-1:OFFS_W]),
      .bank_b (cur_v[1][ADDR_W-1:OFFS_W]),
      .clash  (bank_clash)
   );

   assign a_addr = cur_v[0];
   assign b_addr = cur_v[1];
endmodule

// File: rtl/bbac_checker.sv
module bbac_checker #(
   parameter int ADDR_W   = 18,
   parameter int OFFS_W   = 12,
   parameter int NP       = 2,
   parameter bit CLASH_EN = 1'b1
) (
   input logic                     clk,
   input logic                     rst,
   input logic [NP-1:0][ADDR_W-1:0] ext_v,
   input logic [NP-1:0][ADDR_W-1:0] cur_v,
   input logic [NP-1:0][ADDR_W-1:0] keep_v,
   input logic [NP-1:0]             ld_n_v,
   input logic [NP-1:0]             cnt_n_v,
   input logic [NP-1:0]             rpt_n_v,
   input logic                      clash
);
   generate
      for (genvar p = 0; p < NP; p++) begin : g_chk
         AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
            (rpt_n_v[p] && !ld_n_v[p]) |=> (cur_v[p] == $past(ext_v[p]) && keep_v[p] == $past(ext_v[p]))); // R2 R6
         AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
            (rpt_n_v[p] && ld_n_v[p] && !cnt_n_v[p]) |=> (cur_v[p] == ADDR_W'($past(cur_v[p]) + 1'b1))); // R3 R7 R8
         AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
            (rpt_n_v[p] && ld_n_v[p] && cnt_n_v[p]) |=> $stable(cur_v[p])); // R4
         AST_REPEAT_RESTORES: assert property (@(posedge clk) disable iff (rst)
            !rpt_n_v[p] |=> (cur_v[p] == $past(keep_v[p]))); // R5
         AST_KEEP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
            (ld_n_v[p] || !rpt_n_v[p]) |=> $stable(keep_v[p])); // R9
      end
   endgenerate

   AST_CLASH_MATCH: assert property (@(posedge clk) disable iff (rst)
      clash == (CLASH_EN && (cur_v[0][ADDR_W-1:OFFS_W] == cur_v[1][ADDR_W-1:OFFS_W]))); // R10
endmodule

bind burst_bank_addr_gen bbac_checker #(
   .ADDR_W   (ADDR_W),
   .OFFS_W   (OFFS_W),
   .NP       (NP),
   .CLASH_EN (CLASH_EN)
) u_bbac_chk (
   .clk     (clk),
   .rst     (rst),
   .ext_v   (ext_v),
   .cur_v   (cur_v),
   .keep_v  (keep_v),
   .ld_n_v  (ld_n_v),
   .cnt_n_v (cnt_n_v),
   .rpt_n_v (rpt_n_v),
   .clash   (bank_clash)
);

// File: tb/test_burst_bank_addr_gen.sv
module test_burst_bank_addr_gen;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] a_addr_in = '0, b_addr_in = '0;
   logic          a_load_n = 1'b1, a_count_n = 1'b1, a_repeat_n = 1'b1;
   logic          b_load_n = 1'b1, b_count_n = 1'b1, b_repeat_n = 1'b1;
   logic [AW-1:0] a_addr, b_addr;
   logic          bank_clash;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #10 clk = ~clk;

   burst_bank_addr_gen i_burst_bank_addr_gen (
      .clk(clk), .rst(rst),
      .a_addr_in(a_addr_in), .a_load_n(a_load_n), .a_count_n(a_count_n),
      .a_repeat_n(a_repeat_n), .a_addr(a_addr),
      .b_addr_in(b_addr_in), .b_load_n(b_load_n), .b_count_n(b_count_n),
      .b_repeat_n(b_repeat_n), .b_addr(b_addr),
      .bank_clash(bank_clash)
   );

   // {addr_in, load_n, count_n, repeat_n, expected a_addr}
   localparam logic [2*AW+2:0] VEC [12] = '{
      {18'h00FFE, 1'b0, 1'b1, 1'b1, 18'h00FFE},  // R2 load
      {18'h00000, 1'b1, 1'b0, 1'b1, 18'h00FFF},  // R3 count
      {18'h00000, 1'b1, 1'b0, 1'b1, 18'h01000},  // R7 bank carry
      {18'h00000, 1'b1, 1'b1, 1'b1, 18'h01000},  // R4 hold
      {18'h2AAAA, 1'b0, 1'b0, 1'b0, 18'h00FFE},  // R5 restore beats load and count
      {18'h00000, 1'b1, 1'b1, 1'b0, 18'h00FFE},  // R9 blocked load not captured
      {18'h3FFFE, 1'b0, 1'b0, 1'b1, 18'h3FFFE},  // R6 load beats count
      {18'h00000, 1'b1, 1'b0, 1'b1, 18'h3FFFF},  // R3 count
      {18'h00000, 1'b1, 1'b0, 1'b1, 18'h00000},  // R8 top wrap
      {18'h00000, 1'b1, 1'b1, 1'b0, 18'h3FFFE},  // R9 newest load kept
      {18'h00000, 1'b1, 1'b0, 1'b1, 18'h3FFFF},  // R3 count
      {18'h00000, 1'b1, 1'b1, 1'b0, 18'h3FFFE}   // R9 restore left register alone
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_a(input logic [AW-1:0] ad, input logic ld, input logic cn, input logic rp);
      a_addr_in = ad; a_load_n = ld; a_count_n = cn; a_repeat_n = rp;
   endtask

   task automatic set_b(input logic [AW-1:0] ad, input logic ld, input logic cn, input logic rp);
      b_addr_in = ad; b_load_n = ld; b_count_n = cn; b_repeat_n = rp;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [AW-1:0] b_keep;
      repeat (3) @(negedge clk);
      chk("R1 a_addr", 32'(a_addr), 32'h0);
      chk("R1 b_addr", 32'(b_addr), 32'h0);
      chk("R10 clash at reset", 32'(bank_clash), 32'h1);
      rst = 1'b0;
      set_a('0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R1 restore register cleared", 32'(a_addr), 32'h0);

      b_keep = b_addr;
      for (int i = 0; i < 12; i++) begin
         set_a(VEC[i][2*AW+2:AW+3], VEC[i][AW+2], VEC[i][AW+1], VEC[i][AW]);
         @(negedge clk);
         chk($sformatf("vector %0d a_addr", i), 32'(a_addr), 32'(VEC[i][AW-1:0]));
      end
      chk("R11 b untouched by a", 32'(b_addr), 32'(b_keep));

      // bank clash
      set_a(18'h05123, 1'b0, 1'b1, 1'b1);
      set_b(18'h06123, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      chk("R10 different banks", 32'(bank_clash), 32'h0);
      set_a('0, 1'b1, 1'b1, 1'b1);
      set_b(18'h05FFF, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      chk("R10 same bank", 32'(bank_clash), 32'h1);
      set_b('0, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      chk("R7 b carry", 32'(b_addr), 32'h06000);
      chk("R10 left bank", 32'(bank_clash), 32'h0);
      chk("R11 a untouched by b", 32'(a_addr), 32'h05123);
      set_b('0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R5 b restore", 32'(b_addr), 32'h05FFF);
      chk("R10 restore into a's bank", 32'(bank_clash), 32'h1);

      // reset in mid run
      set_b('0, 1'b1, 1'b1, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 mid-run reset a", 32'(a_addr), 32'h0);
      set_a('0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R1 mid-run restore register cleared", 32'(a_addr), 32'h0);
      set_a('0, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      finish_run();
   end
endmodule